// File: doc/BRIEF.md
# Dual-Select Separate-I/O Static Memory

This block is a synthesizable model of a small static memory: 256 words of 4 bits, with an 8-bit address, its own 4-bit write-data bus and its own 4-bit read-data bus. Two chip selects of opposite polarity enable the part. An active-high select must be HIGH and an active-low select must be LOW. An active-low write enable and an active-low output enable then pick the operation. The three-state output of a discrete part is modelled as a data bus plus one drive-enable flag. No internal tri-state buffers are used.

The control lines are decoded combinationally into one of four modes, following the asynchronous truth table: standby, outputs disabled, read and write. A single internal clock registers the effects of each mode. A write commits on the edge where the write mode is decoded. A read shows the stored word on the outputs after the edge where the read mode is decoded. During a write the output register is preloaded with the incoming word, so a read of the same address right after the write shows the new data at once. Storage is not cleared by reset, and a location must be written before it is read.

Top module: `sram_dsel`

## Requirements
- R1: When the active-low select is HIGH or the active-high select is LOW, the part is in standby. After the next clock edge the drive-enable is 0, and no storage location changes.
- R2: When selected (active-low select LOW, active-high select HIGH) with write enable LOW, the write-data word is stored at the address on that clock edge. The value of output enable has no effect on this.
- R3: When selected with write enable HIGH and output enable LOW, after the next clock edge the drive-enable is 1. The data output then carries the word stored at the sampled address, with bit i of the output equal to bit i of the stored word.
- R4: When selected with write enable HIGH and output enable HIGH, the drive-enable is 0 after the next clock edge.
- R5: While a write is decoded, the drive-enable is 0 after that clock edge, whatever the output enable.
- R6: A read of the same address in the cycle right after a write shows the newly written word after its first edge, with no stale value.
- R7: Whenever the drive-enable is 0, the data output is all zeros.
- R8: After a clock edge with the active-low reset LOW, the drive-enable is 0 and the data output is all zeros.
- R9: Each address holds its own word, and this includes the lowest address (0) and the highest address (255). Writing one address leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| addr | input | 8 | Word address |
| wdata | input | 4 | Write-data bus |
| sel_lo_n | input | 1 | Chip select, active LOW |
| sel_hi | input | 1 | Chip select, active HIGH |
| wr_n | input | 1 | Write enable, active LOW |
| rd_oe_n | input | 1 | Output enable, active LOW |
| rdata | output | 4 | Read-data bus (zero when not driven) |
| rdata_en | output | 1 | Output drive enable, stands in for the three-state control |

## Verification
Two functions meet in one clock edge: the commit of a write into storage, and the preload of the output register with the same word. The word then has to be read back on the very next edge. The bench provokes this by ending a write and starting a read of the same address with no gap. It judges that the drive-enable is low after the write edge, and that the new word, not the previous contents, appears after the first read edge. The bench also issues writes with output enable both LOW and HIGH, and write attempts under each standby condition. The later reads show whether the stored word changed.

// File: rtl/sram_dsel_pkg.sv
// Package: shared types for the dual-select static memory.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sram_dsel_pkg;

    // Operating mode decoded from the select and enable lines.
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } mem_mode_t;

endpackage

// File: rtl/sram_dsel_decode.sv
// Module: sram_dsel_decode
// Turns the two chip selects, write enable and output enable into one
// operating mode. Purely combinational, like the truth table it follows.
// Assumes: every control input has a defined level in each cycle.
module sram_dsel_decode
    import sram_dsel_pkg::*;
(
    input  logic      sel_lo_n,
    input  logic      sel_hi,
    input  logic      wr_n,
    input  logic      rd_oe_n,
    output mem_mode_t mode
);

    logic selected;

    // Part is enabled only with both selects at their active level.
    always_comb selected = !sel_lo_n && sel_hi;

    // Mode priority: standby, then write, then read, else outputs off.
    always_comb begin
        if (!selected)
            mode = MODE_STANDBY;
        else if (!wr_n)
            mode = MODE_WRITE;
        else if (!rd_oe_n)
            mode = MODE_READ;
        else
            mode = MODE_OUT_OFF;
    end

endmodule

// File: rtl/sram_dsel_array.sv
// Module: sram_dsel_array
// Word storage with one synchronous write port and one asynchronous read port.
// Assumes: contents are undefined until written; no reset is applied to them.
module sram_dsel_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Commit the incoming word at the addressed cell on a write edge.
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[addr] <= wr_word;
    end

    // Present the addressed cell to the output stage.
    always_comb rd_word = cells[addr];

endmodule

// File: rtl/sram_dsel_outstage.sv
// Module: sram_dsel_outstage
// Registered output stage. A read loads the stored word and raises the drive
// enable. A write preloads the incoming word with the drive enable low. The
// data bus is forced to zero whenever the drive enable is low.
// Assumes: mode comes from sram_dsel_decode in the same cycle.
module sram_dsel_outstage
    import sram_dsel_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mem_mode_t         mode,
    input  logic [DATA_W-1:0] store_word,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] out_word,
    output logic              out_en
);

    logic [DATA_W-1:0] hold_q;
    logic              en_q;

    // Update the held word and the drive flag from the decoded mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            en_q   <= 1'b0;
        end else begin
            unique case (mode)
                MODE_READ: begin
                    hold_q <= store_word;
                    en_q   <= 1'b1;
                end
                MODE_WRITE: begin
                    hold_q <= wr_word;
                    en_q   <= 1'b0;
                end
                default: en_q <= 1'b0;
            endcase
        end
    end

    // Drive the bus only while enabled; otherwise show zeros.
    always_comb begin
        out_en   = en_q;
        out_word = en_q ? hold_q : '0;
    end

endmodule

// File: rtl/sram_dsel.sv
// Module: sram_dsel (top)
// 2**ADDR_W by DATA_W static memory with separate data buses, two opposite-
// polarity chip selects, active-low write and output enables.
// Assumes: a single clock samples every control, address and data input.
module sram_dsel
    import sram_dsel_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              rd_oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en
);

    mem_mode_t         mode;
    logic              commit;
    logic [DATA_W-1:0] cell_word;

    sram_dsel_decode u_decode (
        .sel_lo_n (sel_lo_n),
        .sel_hi   (sel_hi),
        .wr_n     (wr_n),
        .rd_oe_n  (rd_oe_n),
        .mode     (mode)
    );

    // Writes are held off while the output stage is in reset.
    always_comb commit = rst_n && (mode == MODE_WRITE);

    sram_dsel_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .addr    (addr),
        .wr_word (wdata),
        .rd_word (cell_word)
    );

    sram_dsel_outstage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .store_word (cell_word),
        .wr_word    (wdata),
        .out_word   (rdata),
        .out_en     (rdata_en)
    );

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_lo_n || !sel_hi) |=> !rdata_en); // R1
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && wr_n && !rd_oe_n) |=> rdata_en); // R3
    AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && wr_n && rd_oe_n) |=> !rdata_en); // R4
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_lo_n && sel_hi && !wr_n) |=> !rdata_en); // R5
    AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_lo_n && sel_hi && !wr_n)
         && !sel_lo_n && sel_hi && wr_n && !rd_oe_n && addr == $past(addr))
        |=> rdata == $past(wdata, 2)); // R6
    AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_en |-> rdata == '0); // R7

endmodule

// File: tb/sram_dsel_test.sv
// Directed bench for sram_dsel: one task per scenario, each checking itself.
module sram_dsel_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] addr;
    logic [3:0] wdata;
    logic       sel_lo_n, sel_hi, wr_n, rd_oe_n;
    logic [3:0] rdata;
    logic       rdata_en;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sram_dsel uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_lo_n(sel_lo_n), .sel_hi(sel_hi), .wr_n(wr_n), .rd_oe_n(rd_oe_n),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    // Apply one cycle of stimulus at the falling edge, then settle past the rising edge.
    task automatic cycle(input logic [7:0] a, input logic [3:0] d, input logic sn,
                         input logic s, input logic wn, input logic on);
        @(negedge clk);
        addr = a; wdata = d; sel_lo_n = sn; sel_hi = s; wr_n = wn; rd_oe_n = on;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: en/data actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] d, input logic on);
        cycle(a, d, 1'b0, 1'b1, 1'b0, on);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [3:0] exp);
        cycle(a, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0);
        check(tag, {rdata_en, rdata}, {1'b1, exp});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycle(8'h00, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1);
        cycle(8'h00, 4'h0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 reset", {rdata_en, rdata}, 5'b0_0000);
        rst_n = 1'b1;
    endtask

    task automatic t_patterns();
        wr(8'h00, 4'hA, 1'b1);
        wr(8'hFF, 4'h5, 1'b1);
        wr(8'h5A, 4'hC, 1'b1);
        wr(8'hA5, 4'h3, 1'b1);
        rd_check("R9 addr 0", 8'h00, 4'hA);
        rd_check("R9 addr 255", 8'hFF, 4'h5);
        rd_check("R3 addr 5A", 8'h5A, 4'hC);
        rd_check("R3 addr A5", 8'hA5, 4'h3);
        wr(8'h5A, 4'h9, 1'b1);
        rd_check("R9 neighbour kept", 8'hA5, 4'h3);
        rd_check("R9 overwrite", 8'h5A, 4'h9);
    endtask

    task automatic t_oe_during_write();
        wr(8'h11, 4'h6, 1'b0);
        check("R5 write oe low", {rdata_en, rdata}, 5'b0_0000);
        rd_check("R2 oe low write", 8'h11, 4'h6);
        wr(8'h12, 4'hE, 1'b1);
        check("R5 write oe high", {rdata_en, rdata}, 5'b0_0000);
        rd_check("R2 oe high write", 8'h12, 4'hE);
    endtask

    task automatic t_standby();
        wr(8'h20, 4'h3, 1'b1);
        cycle(8'h20, 4'hC, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R1 standby lo-select high", {rdata_en, rdata}, 5'b0_0000);
        cycle(8'h20, 4'hC, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 standby hi-select low", {rdata_en, rdata}, 5'b0_0000);
        rd_check("R1 no write in standby", 8'h20, 4'h3);
        cycle(8'h20, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R1 read blocked in standby", {rdata_en, rdata}, 5'b0_0000);
    endtask

    task automatic t_out_off();
        rd_check("R3 before disable", 8'h20, 4'h3);
        cycle(8'h20, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1);
        check("R4 oe high disables", {rdata_en, rdata}, 5'b0_0000);
        check("R7 zero when off", {1'b0, rdata}, 5'b0_0000);
    endtask

    task automatic t_write_through();
        wr(8'h40, 4'h1, 1'b1);
        rd_check("R6 old value", 8'h40, 4'h1);
        wr(8'h40, 4'hF, 1'b0);
        check("R5 write after read", {rdata_en, rdata}, 5'b0_0000);
        rd_check("R6 new value at once", 8'h40, 4'hF);
        wr(8'h41, 4'h7, 1'b0);
        rd_check("R6 back-to-back other addr", 8'h41, 4'h7);
        rd_check("R9 previous addr kept", 8'h40, 4'hF);
    endtask

    initial begin
        addr = '0; wdata = '0; sel_lo_n = 1'b1; sel_hi = 1'b0;
        wr_n = 1'b1; rd_oe_n = 1'b1; rst_n = 1'b0;
        t_reset();
        t_patterns();
        t_oe_during_write();
        t_standby();
        t_out_off();
        t_write_through();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule